// File: doc/BRIEF.md
# Shared Memory Slot Mapper

This block holds the ownership map for a shared work memory cut into 32 KB slices. It keeps two groups of eight byte-wide descriptors, one group for data slices and one for code slices. Each descriptor names the bus master that owns its slice, the slot position the slice answers to in that master's window, and an enable bit. A configuration port writes and reads the descriptors one byte at a time.

A lookup port takes a requesting master, a group select and a byte address. It returns a hit flag and the index of the physical slice that serves the request. The slot position is compared with the three address bits just above the 32 KB boundary. Owner codes 2 and 3 both name the signal-processor master, so a descriptor that holds either code answers a signal-processor request made with either code. The memory array, the crossing between master clocks and bus protocol conversion belong to neighbouring blocks.

Top module: `wram_slice_map`

## Requirements
- R1: There are eight data descriptors and eight code descriptors. The configuration address bit 3 selects the group (0 = data, 1 = code) and bits 2:0 select the descriptor. A write to one group never changes the other group, and the lookup group select (0 = data, 1 = code) chooses which group is searched.
- R2: Descriptor bits 6:5 are not stored and always read back as zero. Bits 7 and 4:0 read back as written.
- R3: Descriptor bits 1:0 hold the owner: 0 = first processor, 1 = second processor, and 2 or 3 = signal-processor master. A requester code is matched with the same decoding, so codes 2 and 3 are interchangeable on both sides.
- R4: Descriptor bits 4:2 hold the slot offset. A lookup matches a descriptor only when the offset equals address bits 17:15 of the request. Address bits 14:0 have no effect.
- R5: Descriptor bit 7 is the enable. A descriptor with a clear enable never produces a hit, whatever its owner and offset.
- R6: When several enabled descriptors in the searched group match, the lowest-numbered one wins.
- R7: A lookup that misses drives the hit flag low and the slice index to zero.
- R8: After reset every descriptor reads zero and no lookup hits.
- R9: The lookup result appears on the clock edge after the request is presented. It is computed from the descriptors as they stood before any write taken on that same edge. Configuration reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_addr | input | 4 | Descriptor select: bit 3 group, bits 2:0 index |
| cfg_wdata | input | 8 | Descriptor write data |
| cfg_rdata | output | 8 | Descriptor read data for cfg_addr |
| lk_master | input | 2 | Requesting master code |
| lk_code | input | 1 | Group searched: 0 data, 1 code |
| lk_addr | input | 18 | Requested byte address within the master's window |
| lk_hit | output | 1 | Registered hit flag |
| lk_slice | output | 3 | Registered physical slice index, zero on a miss |

## Verification
The bench compares every cycle against a behavioural model. It aims at overlapping matches: two enabled descriptors that share owner and offset must resolve to the lower index, and a highest-first encoder would report the wrong slice. It programs owner code 3 and looks up with code 2, and the reverse. A mapper that compares raw owner codes would miss these. It also sets bits 6:5 on writes, where a design that stores them reads back a nonzero pad. It disables a descriptor that still matches, where a design that ignores the enable keeps hitting. Writes and lookups share edges, so a design that forwards the new descriptor into the same-cycle lookup returns a result one edge early.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;

   localparam int OWN_W  = 2;
   localparam int SLOT_W = 3;

   typedef enum logic [OWN_W-1:0] {
      OWN_CPU_A = 2'd0,
      OWN_CPU_B = 2'd1,
      OWN_SIG   = 2'd2
   } owner_e;

   typedef struct packed {
      logic              en;
      logic [1:0]        pad;
      logic [SLOT_W-1:0] slot;
      logic [OWN_W-1:0]  owner;
   } desc_t;

   // Both upper owner codes collapse onto the signal-processor master.
   function automatic owner_e canon_owner(input logic [OWN_W-1:0] code);
      return code[1] ? OWN_SIG : owner_e'(code);
   endfunction

endpackage

// File: rtl/wram_desc_bank.sv
module wram_desc_bank
   import wram_map_pkg::*;
#(
   parameter int NUM_DESC = 8,
   localparam int IDX_W = $clog2(NUM_DESC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  desc_t                wr_desc,
   input  logic [IDX_W-1:0]     rd_idx,
   output desc_t                rd_desc,
   input  owner_e               req_owner,
   input  logic [SLOT_W-1:0]    req_slot,
   output logic [NUM_DESC-1:0]  match,
   output logic [NUM_DESC-1:0]  en_vec
);

   desc_t store [NUM_DESC];

   logic unused_pad;
   assign unused_pad = ^wr_desc.pad;

   for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            store[i] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            store[i].en    <= wr_desc.en;
            store[i].pad   <= 2'b00;
            store[i].slot  <= wr_desc.slot;
            store[i].owner <= wr_desc.owner;
         end
      end

      assign en_vec[i] = store[i].en;
      assign match[i]  = store[i].en
                       && (canon_owner(store[i].owner) == req_owner)
                       && (store[i].slot == req_slot);
   end

   assign rd_desc = store[rd_idx];

   // R2: pad bits never leave the bank set
   p_pad_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_desc.pad == 2'b00);

endmodule

// File: rtl/wram_hit_pick.sv
module wram_hit_pick #(
   parameter int NUM_DESC = 8,
   localparam int IDX_W = $clog2(NUM_DESC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_DESC-1:0]  match,
   output logic                 hit,
   output logic [IDX_W-1:0]     idx,
   output logic [NUM_DESC-1:0]  grant
);

   always_comb begin
      hit   = 1'b0;
      idx   = '0;
      grant = '0;
      for (int i = NUM_DESC - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit   = 1'b1;
            idx   = IDX_W'(i);
            grant = NUM_DESC'(1) << i;
         end
      end
   end

   // R6: at most one descriptor is granted, and only one that matched
   p_single_grant_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~match) == '0));

endmodule

// File: rtl/wram_slice_map.sv
module wram_slice_map
   import wram_map_pkg::*;
#(
   parameter int NUM_DESC   = 8,
   parameter int SLOT_LSB   = 15,
   parameter bit LOOKUP_REG = 1'b1,
   localparam int IDX_W  = $clog2(NUM_DESC),
   localparam int ADDR_W = SLOT_LSB + SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W:0]    cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [1:0]        lk_master,
   input  logic              lk_code,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_slice
);

   if (NUM_DESC != (1 << SLOT_W)) begin : g_bad_depth
      $error("NUM_DESC must equal the number of slot positions");
   end
   if (SLOT_LSB < 1) begin : g_bad_lsb
      $error("SLOT_LSB must be positive");
   end

   logic unused_low;
   assign unused_low = ^lk_addr[SLOT_LSB-1:0];

   owner_e            req_owner;
   logic [SLOT_W-1:0] req_slot;
   assign req_owner = canon_owner(lk_master);
   assign req_slot  = lk_addr[SLOT_LSB +: SLOT_W];

   logic [NUM_DESC-1:0] match_g [2];
   logic [NUM_DESC-1:0] en_g    [2];
   desc_t               rd_g    [2];

   for (genvar g = 0; g < 2; g++) begin : g_grp
      wram_desc_bank #(.NUM_DESC(NUM_DESC)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && (cfg_addr[IDX_W] == 1'(g))),
         .wr_idx    (cfg_addr[IDX_W-1:0]),
         .wr_desc   (desc_t'(cfg_wdata)),
         .rd_idx    (cfg_addr[IDX_W-1:0]),
         .rd_desc   (rd_g[g]),
         .req_owner (req_owner),
         .req_slot  (req_slot),
         .match     (match_g[g]),
         .en_vec    (en_g[g])
      );
   end

   assign cfg_rdata = rd_g[cfg_addr[IDX_W]];

   logic                sel_hit;
   logic [IDX_W-1:0]    sel_idx;
   logic [NUM_DESC-1:0] sel_grant;
   logic [NUM_DESC-1:0] sel_en;

   assign sel_en = en_g[lk_code];

   wram_hit_pick #(.NUM_DESC(NUM_DESC)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .match (match_g[lk_code]),
      .hit   (sel_hit),
      .idx   (sel_idx),
      .grant (sel_grant)
   );

   if (LOOKUP_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lk_hit   <= 1'b0;
            lk_slice <= '0;
         end else begin
            lk_hit   <= sel_hit;
            lk_slice <= sel_idx;
         end
      end

      // R5: a registered hit needs an enabled descriptor at the granted slot
      p_hit_enabled_r5 : assert property (@(posedge clk) disable iff (!rst_n)
         sel_hit |=> lk_hit && ($past(sel_grant & sel_en) != '0));
   end else begin : g_comb_out
      assign lk_hit   = sel_hit;
      assign lk_slice = sel_idx;
   end

   // R7: a miss always carries a zero index
   p_miss_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_slice == '0);

   // R2: pad bits read back clear at the port
   p_rdata_pad_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[6:5] == 2'b00);

endmodule

// File: tb/wram_slice_map_test.sv
module wram_slice_map_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [1:0]  lk_master = '0;
   logic        lk_code = 1'b0;
   logic [17:0] lk_addr = '0;
   logic        lk_hit;
   logic [2:0]  lk_slice;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [7:0] mdl [16];
   bit   exp_hit;
   int   exp_idx;

   always #5 clk = ~clk;

   wram_slice_map uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_master(lk_master),
      .lk_code(lk_code), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_slice(lk_slice)
   );

   function automatic int norm(input int c);
      return (c >= 2) ? 2 : c;
   endfunction

   task automatic check(input string tag, input int act, input int exp, input string what);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // One cycle: drive at negedge, model the edge, check at next negedge.
   task automatic step(input bit we, input int wa, input int wd,
                       input int m, input bit code, input int slot, input string tag);
      cfg_we    = we;
      cfg_addr  = 4'(wa);
      cfg_wdata = 8'(wd);
      lk_master = 2'(m);
      lk_code   = code;
      lk_addr   = {3'(slot), 15'h2A5C};
      exp_hit = 1'b0;
      exp_idx = 0;
      for (int i = 7; i >= 0; i--) begin
         int d;
         d = mdl[(code ? 8 : 0) + i];
         if (d[7] && norm(d & 3) == norm(m) && ((d >> 2) & 7) == slot) begin
            exp_hit = 1'b1;
            exp_idx = i;
         end
      end
      if (we) mdl[wa] = 8'(wd) & 8'h9F;
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(lk_hit), int'(exp_hit), "hit");
      check(tag, int'(lk_slice), exp_idx, "slice");
      check(tag, int'(cfg_rdata), int'(mdl[wa]), "rdata");
   endtask

   function automatic int dsc(input int en, input int slot, input int own);
      return (en << 7) | (slot << 2) | own;
   endfunction

   initial begin
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: all descriptors clear, nothing hits
      for (int a = 0; a < 16; a++)
         step(1'b0, a, 0, a % 4, a[3], a % 8, "R8");
      // R4: owner 1, slot 5 at data descriptor 3
      step(1'b1, 3, dsc(1, 5, 1), 0, 0, 0, "R9");
      step(1'b0, 3, 0, 1, 0, 5, "R4");
      step(1'b0, 3, 0, 1, 0, 4, "R4");
      step(1'b0, 3, 0, 0, 0, 5, "R3");
      // R1: same request in the code group misses
      step(1'b0, 11, 0, 1, 1, 5, "R1");
      // R2: pad bits written set, read back clear
      step(1'b1, 12, dsc(1, 2, 3) | 8'h60, 2, 1, 2, "R2");
      // R3: owner code 3 answers requester code 2, and the reverse
      step(1'b0, 12, 0, 2, 1, 2, "R3");
      step(1'b1, 13, dsc(1, 6, 2), 3, 1, 2, "R3");
      step(1'b0, 13, 0, 3, 1, 6, "R3");
      step(1'b0, 13, 0, 1, 1, 6, "R3");
      // R5: matching but disabled
      step(1'b1, 7, dsc(0, 1, 0), 0, 0, 1, "R5");
      step(1'b0, 7, 0, 0, 0, 1, "R5");
      // R6: two matches, lowest wins; then drop the low one
      step(1'b1, 6, dsc(1, 4, 0), 0, 0, 4, "R6");
      step(1'b1, 2, dsc(1, 4, 0), 0, 0, 4, "R9");
      step(1'b0, 2, 0, 0, 0, 4, "R6");
      step(1'b1, 2, dsc(0, 4, 0), 0, 0, 4, "R6");
      step(1'b0, 2, 0, 0, 0, 4, "R6");
      // R7: miss gives zero index
      step(1'b0, 0, 0, 2, 0, 7, "R7");
      // Mixed traffic
      for (int k = 0; k < 400; k++) begin
         int r;
         r = int'($urandom);
         step(r[0], (r >> 1) & 15, (r >> 5) & 255, (r >> 13) & 3,
              r[15], (r >> 16) & 7, "R6");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #2ms;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule